// File: doc/BRIEF.md
# Alternating Fetch/Execute Register Bank with In-File Program Counter

This block holds the eight 16-bit registers of a small CPU and sequences its two-phase cycle. The phases alternate on every clock edge. In the fetch phase the block drives the active program counter onto the memory address. At the closing edge it captures the instruction word from memory and adds one to that counter. In the execute phase the surrounding datapath reads two registers, may write one, and may load the equality and carry flags from an ALU result. Decoding of the instruction word and the ALU itself live outside this block.

The program counter is not a separate register. It is register 7 of the file. While an interrupt handler runs, register 6 takes over that role. Interrupts are taken only at the edge that closes an execute phase, and only when they are enabled. Taking one sets an in-handler flag, and from then on fetches address and advance register 6. A return control bit, sampled in execute, clears the flag so that fetches go back to register 7. When the block is not in the handler, register 6 behaves like any other general register.

Top module: `fx_core_regs`

## Requirements
- R1: While reset is held, the phase is fetch, all eight registers, the instruction word and both flags read zero, and the in-handler flag is clear.
- R2: The phase output toggles on every clock edge after reset: fetch (phase_exec=0), then execute (phase_exec=1), then fetch again, with no exceptions.
- R3: When the block is outside a handler, mem_addr equals register 7. At the edge that closes a fetch, instr captures mem_rdata and register 7 increases by one modulo 2^16 (0xFFFF becomes 0x0000).
- R4: Inside a handler, mem_addr equals register 6. A fetch captures the instruction and increments register 6, and register 7 keeps its value.
- R5: The write port (wr_en, wr_sel, wr_data) loads register wr_sel at the edge that closes an execute phase. During a fetch phase, a write request changes no register.
- R6: The two read ports rd_a_data and rd_b_data show, combinationally, the register selected by rd_a_sel and rd_b_sel. Any of the eight registers can be selected, register 7 included.
- R7: If execute writes the active program counter, the next fetch address is exactly the written value, with no increment applied first.
- R8: When flag_we is high at the edge that closes an execute phase, flag_eq becomes 1 exactly when alu_result is zero and flag_cy takes alu_carry. Otherwise, or during a fetch, both flags hold.
- R9: A request (irq_req high with irq_en high) sets the in-handler flag at the edge that closes an execute phase. A request seen only during fetch, or with irq_en low, is not taken.
- R10: rti high at the edge that closes an execute phase clears the in-handler flag, and it wins over a simultaneous request. rti during a fetch has no effect.
- R11: Outside a handler, register 6 keeps a written value across fetches and is never incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 16 | Active program counter, the fetch address |
| mem_rdata | input | 16 | Instruction word from memory, captured at the end of fetch |
| instr | output | 16 | Latched instruction word |
| phase_exec | output | 1 | 0 = fetch phase, 1 = execute phase |
| in_isr | output | 1 | Interrupt handler active (register 6 is the program counter) |
| rd_a_sel | input | 3 | Read port A register select |
| rd_a_data | output | 16 | Read port A data |
| rd_b_sel | input | 3 | Read port B register select |
| rd_b_data | output | 16 | Read port B data |
| wr_en | input | 1 | Register write request (effective in execute only) |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 16 | Register write data |
| flag_we | input | 1 | Flag load request (effective in execute only) |
| alu_result | input | 16 | ALU result used for the equality flag |
| alu_carry | input | 1 | ALU carry out |
| flag_eq | output | 1 | Equality flag |
| flag_cy | output | 1 | Carry flag |
| irq_req | input | 1 | Interrupt request |
| irq_en | input | 1 | Interrupt enable |
| rti | input | 1 | Return-from-interrupt control bit |

## Verification
The fetch path is tried three ways: with register 7 active, with register 6 active inside a handler, and across the 0xFFFF wrap. Together these separate a counter that advances the wrong register from one that fails to wrap. Write and flag-load requests are sent in both phases, which tells apart a port gated on the phase from one that is always live. A write to the active counter shows whether the next fetch address skips the increment. Interrupt requests are tried while disabled, during fetch only, while already in a handler, and together with rti, so acceptance timing, enable gating and the rti priority are each checked on their own.

// File: rtl/fx_pkg.sv
package fx_pkg;

    // Cycle phase of the two-step machine
    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } fx_phase_e;

endpackage

// File: rtl/fx_seq.sv
module fx_seq
    import fx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      irq_req_i,
    input  logic      irq_en_i,
    input  logic      rti_i,
    output fx_phase_e phase_o,
    output logic      in_isr_o
);

    typedef struct packed {
        fx_phase_e phase;
        logic      in_isr;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.phase == PH_FETCH) begin
            s_d.phase = PH_EXEC;
        end else begin
            s_d.phase = PH_FETCH;
            // Handler entry and exit happen only at the execute/fetch boundary
            if (rti_i) begin
                s_d.in_isr = 1'b0;
            end else if (irq_req_i && irq_en_i) begin
                s_d.in_isr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_FETCH, in_isr: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o  = s_q.phase;
    assign in_isr_o = s_q.in_isr;

    // R9: an enabled request at the end of execute enters the handler
    a_r9_irq_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EXEC && irq_req_i && irq_en_i && !rti_i) |=> in_isr_o);

    // R10: rti at the end of execute leaves the handler
    a_r10_rti_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_EXEC && rti_i) |=> !in_isr_o);

    // R9, R10: the handler flag never moves across a fetch edge
    a_r10_fetch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == PH_FETCH) |=> $stable(in_isr_o));

    // R9: a disabled request leaves the flag unchanged
    a_r9_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en_i && !rti_i) |=> $stable(in_isr_o));

endmodule

// File: rtl/fx_regs.sv
module fx_regs
    import fx_pkg::*;
#(
    parameter int unsigned W          = 16,
    parameter int unsigned NREG       = 8,
    parameter int unsigned PC_IDX     = 7,
    parameter int unsigned ISR_PC_IDX = 6,
    localparam int unsigned SEL_W     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fx_phase_e        phase_i,
    input  logic             in_isr_i,
    input  logic [W-1:0]     mem_rdata_i,
    output logic [W-1:0]     mem_addr_o,
    output logic [W-1:0]     instr_o,
    input  logic [SEL_W-1:0] rd_a_sel_i,
    output logic [W-1:0]     rd_a_data_o,
    input  logic [SEL_W-1:0] rd_b_sel_i,
    output logic [W-1:0]     rd_b_data_o,
    input  logic             wr_en_i,
    input  logic [SEL_W-1:0] wr_sel_i,
    input  logic [W-1:0]     wr_data_i
);

    localparam logic [SEL_W-1:0] MAIN_PC = SEL_W'(PC_IDX);
    localparam logic [SEL_W-1:0] ISR_PC  = SEL_W'(ISR_PC_IDX);

    typedef struct packed {
        logic [NREG-1:0][W-1:0] rf;
        logic [W-1:0]           ir;
    } rf_t;

    rf_t              r_d, r_q;
    logic [SEL_W-1:0] act_sel;

    assign act_sel = in_isr_i ? ISR_PC : MAIN_PC;

    always_comb begin
        r_d = r_q;
        if (phase_i == PH_FETCH) begin
            r_d.ir          = mem_rdata_i;
            r_d.rf[act_sel] = r_q.rf[act_sel] + W'(1);
        end else if (wr_en_i) begin
            // Execute write; a write to the active counter simply replaces it
            r_d.rf[wr_sel_i] = wr_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr_o  = r_q.rf[act_sel];
    assign instr_o     = r_q.ir;
    assign rd_a_data_o = r_q.rf[rd_a_sel_i];
    assign rd_b_data_o = r_q.rf[rd_b_sel_i];

    // R3, R4: the fetched-from counter advances by one
    a_r3_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_FETCH) |=> (r_q.rf[$past(act_sel)] == $past(mem_addr_o) + W'(1)));

    // R3: the instruction word is captured at the end of fetch
    a_r3_ir_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_FETCH) |=> (instr_o == $past(mem_rdata_i)));

    // R5: an execute write lands in the selected register
    a_r5_exec_write: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_EXEC && wr_en_i) |=> (r_q.rf[$past(wr_sel_i)] == $past(wr_data_i)));

    // R5: a write request during fetch is dropped
    a_r5_fetch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_FETCH && wr_en_i && wr_sel_i != act_sel)
        |=> (r_q.rf[$past(wr_sel_i)] == $past(r_q.rf[wr_sel_i])));

    // R3: execute without a write leaves the instruction word alone
    a_r3_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_EXEC) |=> $stable(instr_o));

endmodule

// File: rtl/fx_flags.sv
module fx_flags
    import fx_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  fx_phase_e    phase_i,
    input  logic         flag_we_i,
    input  logic [W-1:0] alu_result_i,
    input  logic         alu_carry_i,
    output logic         eq_o,
    output logic         cy_o
);

    typedef struct packed {
        logic eq;
        logic cy;
    } flags_t;

    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (phase_i == PH_EXEC && flag_we_i) begin
            f_d.eq = (alu_result_i == '0);
            f_d.cy = alu_carry_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign eq_o = f_q.eq;
    assign cy_o = f_q.cy;

    // R8: flag load in execute
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_EXEC && flag_we_i)
        |=> (eq_o == ($past(alu_result_i) == '0) && cy_o == $past(alu_carry_i)));

    // R8: flags hold in fetch or without a load request
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_FETCH || !flag_we_i) |=> ($stable(eq_o) && $stable(cy_o)));

endmodule

// File: rtl/fx_core_regs.sv
module fx_core_regs
    import fx_pkg::*;
#(
    parameter int unsigned W          = 16,
    parameter int unsigned NREG       = 8,
    parameter int unsigned PC_IDX     = 7,
    parameter int unsigned ISR_PC_IDX = 6,
    localparam int unsigned SEL_W     = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [W-1:0]     mem_addr,
    input  logic [W-1:0]     mem_rdata,
    output logic [W-1:0]     instr,
    output logic             phase_exec,
    output logic             in_isr,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [W-1:0]     rd_a_data,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [W-1:0]     rd_b_data,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [W-1:0]     wr_data,
    input  logic             flag_we,
    input  logic [W-1:0]     alu_result,
    input  logic             alu_carry,
    output logic             flag_eq,
    output logic             flag_cy,
    input  logic             irq_req,
    input  logic             irq_en,
    input  logic             rti
);

    fx_phase_e phase;
    logic      isr;

    fx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_req_i (irq_req),
        .irq_en_i  (irq_en),
        .rti_i     (rti),
        .phase_o   (phase),
        .in_isr_o  (isr)
    );

    fx_regs #(
        .W          (W),
        .NREG       (NREG),
        .PC_IDX     (PC_IDX),
        .ISR_PC_IDX (ISR_PC_IDX)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_i     (phase),
        .in_isr_i    (isr),
        .mem_rdata_i (mem_rdata),
        .mem_addr_o  (mem_addr),
        .instr_o     (instr),
        .rd_a_sel_i  (rd_a_sel),
        .rd_a_data_o (rd_a_data),
        .rd_b_sel_i  (rd_b_sel),
        .rd_b_data_o (rd_b_data),
        .wr_en_i     (wr_en),
        .wr_sel_i    (wr_sel),
        .wr_data_i   (wr_data)
    );

    fx_flags #(
        .W (W)
    ) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase_i      (phase),
        .flag_we_i    (flag_we),
        .alu_result_i (alu_result),
        .alu_carry_i  (alu_carry),
        .eq_o         (flag_eq),
        .cy_o         (flag_cy)
    );

    assign phase_exec = (phase == PH_EXEC);
    assign in_isr     = isr;

    // R2: phases alternate on every edge after reset
    a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (phase_exec != $past(phase_exec)));

    // R7: a write to the active counter becomes the next fetch address
    a_r7_pc_write: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_exec && wr_en && !rti && !(irq_req && irq_en)
         && wr_sel == SEL_W'(isr ? ISR_PC_IDX : PC_IDX))
        |=> (mem_addr == $past(wr_data)));

endmodule

// File: tb/sim_fx_core_regs.sv
`timescale 1ns/1ps
module sim_fx_core_regs;

    localparam int K_PH  = 0;
    localparam int K_AD  = 1;
    localparam int K_IR  = 2;
    localparam int K_ISR = 3;
    localparam int K_EQ  = 4;
    localparam int K_CY  = 5;
    localparam int K_RA  = 6;
    localparam int K_RB  = 7;

    typedef struct {
        string       req;
        int          kind;
        logic [15:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_rdata, instr, rd_a_data, rd_b_data, wr_data, alu_result;
    logic        phase_exec, in_isr, wr_en, flag_we, alu_carry, flag_eq, flag_cy;
    logic        irq_req, irq_en, rti;
    logic [2:0]  rd_a_sel, rd_b_sel, wr_sel;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // model state
    logic [15:0] m_rf[8];
    logic [15:0] m_ir;
    logic        m_exec, m_isr, m_eq, m_cy;

    always #4 clk = ~clk;

    fx_core_regs u0 (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .instr(instr), .phase_exec(phase_exec), .in_isr(in_isr),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel),
        .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .flag_we(flag_we), .alu_result(alu_result), .alu_carry(alu_carry),
        .flag_eq(flag_eq), .flag_cy(flag_cy), .irq_req(irq_req),
        .irq_en(irq_en), .rti(rti)
    );

    function automatic logic [15:0] sample(int kind);
        case (kind)
            K_PH:    return {15'd0, phase_exec};
            K_AD:    return mem_addr;
            K_IR:    return instr;
            K_ISR:   return {15'd0, in_isr};
            K_EQ:    return {15'd0, flag_eq};
            K_CY:    return {15'd0, flag_cy};
            K_RA:    return rd_a_data;
            default: return rd_b_data;
        endcase
    endfunction

    task automatic push(string req, int kind, logic [15:0] exp);
        item_t it;
        it.req = req; it.kind = kind; it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic idle();
        mem_rdata = 16'h0; wr_en = 1'b0; wr_sel = 3'd0; wr_data = 16'h0;
        flag_we = 1'b0; alu_result = 16'h0; alu_carry = 1'b0;
        irq_req = 1'b0; irq_en = 1'b0; rti = 1'b0;
    endtask

    task automatic push_all(string req);
        push("R2", K_PH, {15'd0, m_exec});
        push(req, K_AD, m_rf[m_isr ? 6 : 7]);
        push(req, K_IR, m_ir);
        push(req, K_ISR, {15'd0, m_isr});
        push(req, K_EQ, {15'd0, m_eq});
        push(req, K_CY, {15'd0, m_cy});
        push("R6", K_RA, m_rf[rd_a_sel]);
        push("R6", K_RB, m_rf[rd_b_sel]);
    endtask

    // Driver: called at a falling edge with inputs already set
    task automatic step(string req);
        if (!m_exec) begin
            m_ir = mem_rdata;
            m_rf[m_isr ? 6 : 7] = m_rf[m_isr ? 6 : 7] + 16'd1;
            m_exec = 1'b1;
        end else begin
            if (wr_en) m_rf[wr_sel] = wr_data;
            if (flag_we) begin
                m_eq = (alu_result == 16'h0);
                m_cy = alu_carry;
            end
            if (rti) m_isr = 1'b0;
            else if (irq_req && irq_en) m_isr = 1'b1;
            m_exec = 1'b0;
        end
        push_all(req);
        @(negedge clk);
        idle();
    endtask

    // Monitor: compares after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb.pop_front();
                act = sample(it.kind);
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle();
        rd_a_sel = 3'd0; rd_b_sel = 3'd7;
        for (int i = 0; i < 8; i++) m_rf[i] = 16'h0;
        m_ir = 16'h0; m_exec = 1'b0; m_isr = 1'b0; m_eq = 1'b0; m_cy = 1'b0;

        // R1: reset state
        repeat (2) @(negedge clk);
        push_all("R1");
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: first fetch from register 7
        mem_rdata = 16'h1234; step("R3");
        // R5: execute write to R0 and flag load
        rd_a_sel = 3'd0; wr_en = 1'b1; wr_sel = 3'd0; wr_data = 16'hAAAA;
        flag_we = 1'b1; alu_result = 16'h0; alu_carry = 1'b1; step("R5");
        // R5, R8, R10: write, flag load and rti in fetch are all ignored
        rd_b_sel = 3'd1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 16'h5555;
        flag_we = 1'b1; alu_result = 16'h0005; alu_carry = 1'b0; rti = 1'b1;
        mem_rdata = 16'h0F0F; step("R5");
        // R7: write the active counter
        rd_b_sel = 3'd7; wr_en = 1'b1; wr_sel = 3'd7; wr_data = 16'hFFFF; step("R7");
        // R3: wrap from 0xFFFF
        mem_rdata = 16'hBEEF; step("R3");
        // R8: non-zero result clears EQ; R11 setup writes R6
        flag_we = 1'b1; alu_result = 16'h8000; alu_carry = 1'b0;
        wr_en = 1'b1; wr_sel = 3'd6; wr_data = 16'h0100; step("R8");
        // R11: R6 untouched by fetch outside a handler
        rd_a_sel = 3'd6; mem_rdata = 16'h2222; step("R11");
        // R9: disabled request in execute not taken
        irq_req = 1'b1; irq_en = 1'b0; step("R9");
        // R9: enabled request during fetch only is not taken
        irq_req = 1'b1; irq_en = 1'b1; step("R9");
        // R9: enabled request at end of execute is taken
        irq_req = 1'b1; irq_en = 1'b1; flag_we = 1'b1; alu_result = 16'h0; alu_carry = 1'b1;
        step("R9");
        // R4: handler fetch uses and advances R6
        mem_rdata = 16'hCAFE; step("R4");
        // R10: rti wins over a simultaneous request
        rti = 1'b1; irq_req = 1'b1; irq_en = 1'b1; step("R10");
        mem_rdata = 16'h3333; step("R3");
        // R9: enter handler again
        irq_req = 1'b1; irq_en = 1'b1; step("R9");
        // R10: rti during fetch ignored
        rti = 1'b1; mem_rdata = 16'h4444; step("R10");
        // R7: writing R6 inside a handler redirects the next fetch
        wr_en = 1'b1; wr_sel = 3'd6; wr_data = 16'h0200; step("R7");
        mem_rdata = 16'h5555; step("R4");
        // R10: leave the handler
        rti = 1'b1; step("R10");
        mem_rdata = 16'h6666; step("R3");
        // R5, R6: fill the general registers and read them back
        for (int i = 0; i < 6; i++) begin
            rd_a_sel = 3'(i); rd_b_sel = 3'(5 - i);
            wr_en = 1'b1; wr_sel = 3'(i); wr_data = 16'h1000 + 16'(i * 16'h0111);
            step("R5");
            rd_a_sel = 3'(i); mem_rdata = 16'(16'h7000 + i); step("R6");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule